// File: doc/BRIEF.md
# Programmable Down-Counter / Square-Wave Timer

This block is a 16-bit down-counter whose count events come from one of four single-bit sources in the system clock domain. The sources are an external pin, the bit clock of transmitter A, the bit clock of transmitter B and a crystal-derived clock. Each source is sampled as a level, and only its rising edges count. A 3-bit mode field chooses two things at once: counter or timer behaviour, and which source advances the count. Some modes first divide the chosen source by sixteen.

Software writes a start value, then issues a start strobe. In counter mode the output stays high until the count steps from one to zero. It then goes low and stays low until a stop strobe arrives. In timer mode the count reloads itself at each zero crossing and the output toggles, which gives a continuous square wave. A ready flag marks every zero crossing. Only the stop strobe clears it. The output is never gated by any interrupt mask.

Top module: `cntr_timer`

## Requirements
- R1: After reset, `wave_o` is 1 and `ready_o` is 0.
- R2: Mode 000 counts rising edges of `ext_lvl_i`, mode 001 counts rising edges of `txa_lvl_i`, and mode 010 counts rising edges of `txb_lvl_i`. All three are counter modes.
- R3: Mode 011 (counter) and mode 111 (timer) advance once per 16 rising edges of `xtal_lvl_i`. Mode 101 (timer) advances once per 16 rising edges of `ext_lvl_i`.
- R4: Mode 100 is a timer on each rising edge of `ext_lvl_i`, and mode 110 is a timer on each rising edge of `xtal_lvl_i`. Bit 2 of the mode set to 1 means timer.
- R5: In counter mode, after a start with preload P ≥ 1, `wave_o` stays 1 through the first P−1 counted edges and becomes 0 on the P-th.
- R6: In counter mode, once `wave_o` is 0, further counted edges leave it at 0. Only `stop_i` returns it to 1.
- R7: In timer mode with preload P ≥ 1, `wave_o` toggles after every P counted edges and the count reloads P automatically. The period is therefore 2·P counted edges, and the first toggle goes from 1 to 0.
- R8: `ready_o` becomes 1 at each zero crossing. It stays 1 until `stop_i`, which clears it in the following cycle.
- R9: A source held high for several cycles counts as one edge.
- R10: Rising edges on sources that the current mode does not select do not change `wave_o` or `ready_o`.
- R11: Any change of the mode field clears both divide-by-16 prescalers, so a partial group of edges taken before the change is discarded.
- R12: `start_i` reloads the preload value and sets `wave_o` to 1, including while the block is running. When `start_i` and `stop_i` coincide, stop wins and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_lvl_i | input | 1 | External pin level, already synchronized |
| txa_lvl_i | input | 1 | Transmitter A 1x bit clock level |
| txb_lvl_i | input | 1 | Transmitter B 1x bit clock level |
| xtal_lvl_i | input | 1 | Crystal clock level, reduced into the system domain |
| mode_i | input | 3 | Mode and clock-source select |
| preload_i | input | CNT_W | Start and reload value |
| start_i | input | 1 | Start strobe: load preload and run |
| stop_i | input | 1 | Stop strobe: halt, output high, ready cleared |
| wave_o | output | 1 | Square wave (timer) or terminal-count output (counter) |
| ready_o | output | 1 | Zero-crossing flag |

## Verification
The bench builds the block with its defaults: a 16-bit count and a 4-bit prescaler, so the divider is sixteen. Small preloads of one to three let every mode reach its zero crossing within a few dozen source edges, including the divided modes, where the 15th and 16th edges mark the boundary. The bench also reaches the timer's second and third half-periods, the prescaler clear on a mode toggle, and a restart in the middle of a count.

// File: rtl/cntr_timer_pkg.sv
package cntr_timer_pkg;

  localparam int unsigned NUM_SRC = 4;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_TXA  = 2'd1,
    SRC_TXB  = 2'd2,
    SRC_XTAL = 2'd3
  } src_e;

  typedef struct packed {
    logic timer;
    src_e src;
    logic div16;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [2:0] m);
    mode_dec_t d;
    d.timer = m[2];
    unique case (m)
      3'b000:  begin d.src = SRC_EXT;  d.div16 = 1'b0; end
      3'b001:  begin d.src = SRC_TXA;  d.div16 = 1'b0; end
      3'b010:  begin d.src = SRC_TXB;  d.div16 = 1'b0; end
      3'b011:  begin d.src = SRC_XTAL; d.div16 = 1'b1; end
      3'b100:  begin d.src = SRC_EXT;  d.div16 = 1'b0; end
      3'b101:  begin d.src = SRC_EXT;  d.div16 = 1'b1; end
      3'b110:  begin d.src = SRC_XTAL; d.div16 = 1'b0; end
      default: begin d.src = SRC_XTAL; d.div16 = 1'b1; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ct_edge_det.sv
module ct_edge_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic edge_i,
  output logic tick_o
);

  localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | edge_i;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = edge_i & ~clr_i & (cnt_q == LAST);

endmodule

// File: rtl/ct_src_sel.sv
module ct_src_sel
  import cntr_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] lvl_i,
  input  logic [2:0]         mode_i,
  output logic               tick_o,
  output logic               timer_o
);

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] div_tick;
  logic [2:0]         mode_q;
  logic [2:0]         mode_d;
  logic               mode_chg;
  mode_dec_t          dec;

  ct_edge_det #(.N(NUM_SRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_i),
    .rise_o (rise)
  );

  always_comb begin
    mode_d   = mode_i;
    mode_chg = (mode_i != mode_q);
    dec      = decode_mode(mode_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_d;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pre
    if (g == int'(SRC_EXT) || g == int'(SRC_XTAL)) begin : g_on
      ct_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (mode_chg),
        .edge_i (rise[g]),
        .tick_o (div_tick[g])
      );
    end else begin : g_off
      assign div_tick[g] = 1'b0;
    end
  end

  always_comb begin
    if (dec.div16) begin
      tick_o = div_tick[dec.src];
    end else begin
      tick_o = rise[dec.src];
    end
    timer_o = dec.timer;
  end

endmodule

// File: rtl/ct_core.sv
module ct_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             timer_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             wave_o,
  output logic             ready_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] rel_q, rel_d;
  logic             run_q, run_d;
  logic             wave_q, wave_d;
  logic             rdy_q, rdy_d;
  logic             at_term;

  always_comb begin
    cnt_d   = cnt_q;
    rel_d   = rel_q;
    run_d   = run_q;
    wave_d  = wave_q;
    rdy_d   = rdy_q;
    at_term = (cnt_q == ONE);
    if (stop_i) begin
      run_d  = 1'b0;
      wave_d = 1'b1;
      rdy_d  = 1'b0;
    end else if (start_i) begin
      cnt_d  = preload_i;
      rel_d  = preload_i;
      run_d  = 1'b1;
      wave_d = 1'b1;
    end else if (run_q && tick_i) begin
      if (at_term) begin
        rdy_d = 1'b1;
        if (timer_i) begin
          cnt_d  = rel_q;
          wave_d = ~wave_q;
        end else begin
          cnt_d  = '0;
          wave_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      run_q  <= run_d;
      wave_q <= wave_d;
      rdy_q  <= rdy_d;
    end
  end

  assign wave_o  = wave_q;
  assign ready_o = rdy_q;

endmodule

// File: rtl/cntr_timer.sv
module cntr_timer
  import cntr_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_lvl_i,
  input  logic             txa_lvl_i,
  input  logic             txb_lvl_i,
  input  logic             xtal_lvl_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             wave_o,
  output logic             ready_o
);

  logic [NUM_SRC-1:0] lvl;
  logic               sel_tick;
  logic               sel_timer;

  always_comb begin
    lvl[SRC_EXT]  = ext_lvl_i;
    lvl[SRC_TXA]  = txa_lvl_i;
    lvl[SRC_TXB]  = txb_lvl_i;
    lvl[SRC_XTAL] = xtal_lvl_i;
  end

  ct_src_sel #(.PRE_W(PRE_W)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .mode_i  (mode_i),
    .tick_o  (sel_tick),
    .timer_o (sel_timer)
  );

  ct_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sel_tick),
    .timer_i   (sel_timer),
    .preload_i (preload_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wave_o    (wave_o),
    .ready_o   (ready_o)
  );

endmodule

// File: rtl/cntr_timer_chk.sv
module cntr_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       start_i,
  input logic       stop_i,
  input logic       sel_tick,
  input logic       wave_o,
  input logic       ready_o
);

  // R8
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (wave_o && !ready_o));

  // R12
  start_raises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> wave_o);

  // R6
  counter_hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[2] && !wave_o && !stop_i && !start_i) |=> !wave_o);

  // R10
  wave_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !sel_tick) |=> ($stable(wave_o) && $stable(ready_o)));

  // R8
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !stop_i) |=> ready_o);

endmodule

bind cntr_timer cntr_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .sel_tick (sel_tick),
  .wave_o   (wave_o),
  .ready_o  (ready_o)
);

// File: tb/cntr_timer_bench.sv
module cntr_timer_bench;

  localparam int CNT_W = 16;

  logic             clk;
  logic             rst_n;
  logic             ext_l, txa_l, txb_l, xtal_l;
  logic [2:0]       mode;
  logic [CNT_W-1:0] preload;
  logic             start, stop;
  logic             wave, ready;

  typedef struct {
    logic  wave;
    logic  ready;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  cntr_timer #(.CNT_W(CNT_W), .PRE_W(4)) u_cntr_timer (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_lvl_i  (ext_l),
    .txa_lvl_i  (txa_l),
    .txb_lvl_i  (txb_l),
    .xtal_lvl_i (xtal_l),
    .mode_i     (mode),
    .preload_i  (preload),
    .start_i    (start),
    .stop_i     (stop),
    .wave_o     (wave),
    .ready_o    (ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (wave !== e.wave || ready !== e.ready) begin
          n_fail++;
          $display("FAIL %s: wave/ready actual %b/%b expected %b/%b",
                   e.tag, wave, ready, e.wave, e.ready);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic w, input logic r, input string tag);
    exp_t e;
    e.wave  = w;
    e.ready = r;
    e.tag   = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  task automatic set_lvl(input int idx, input logic v);
    case (idx)
      0: ext_l  = v;
      1: txa_l  = v;
      2: txb_l  = v;
      default: xtal_l = v;
    endcase
  endtask

  task automatic pulse(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      set_lvl(idx, 1'b1);
      step();
      set_lvl(idx, 1'b0);
      step();
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    step();
    mode = m;
    step();
  endtask

  task automatic do_start(input int pl);
    step();
    preload = CNT_W'(pl);
    start   = 1'b1;
    step();
    start   = 1'b0;
  endtask

  task automatic do_stop();
    step();
    stop = 1'b1;
    step();
    stop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_l = 0; txa_l = 0; txb_l = 0; xtal_l = 0;
    mode = 3'b000; preload = '0; start = 0; stop = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    expect_out(1'b1, 1'b0, "R1 reset state");

    // counter on external pin
    set_mode(3'b000);
    do_start(3);
    expect_out(1'b1, 1'b0, "R12 start drives high");
    pulse(0, 2);
    expect_out(1'b1, 1'b0, "R5 before terminal");
    pulse(0, 1);
    expect_out(1'b0, 1'b1, "R5 terminal count low, R8 ready");
    pulse(0, 3);
    expect_out(1'b0, 1'b1, "R6 stays low after terminal");
    do_stop();
    expect_out(1'b1, 1'b0, "R6 stop restores high, R8 cleared");

    // edge detection
    do_start(2);
    set_lvl(0, 1'b1);
    repeat (4) step();
    set_lvl(0, 1'b0);
    step();
    expect_out(1'b1, 1'b0, "R9 held level counts once");
    pulse(0, 1);
    expect_out(1'b0, 1'b1, "R9 second edge reaches terminal");
    do_stop();

    // transmitter A source
    set_mode(3'b001);
    do_start(2);
    pulse(0, 2); pulse(2, 2); pulse(3, 2);
    expect_out(1'b1, 1'b0, "R10 unselected sources ignored (mode 001)");
    pulse(1, 2);
    expect_out(1'b0, 1'b1, "R2 txa counts in mode 001");
    do_stop();

    // transmitter B source
    set_mode(3'b010);
    do_start(1);
    pulse(1, 3);
    expect_out(1'b1, 1'b0, "R10 txa ignored in mode 010");
    pulse(2, 1);
    expect_out(1'b0, 1'b1, "R2 txb counts in mode 010");
    do_stop();

    // crystal divided by 16, counter
    set_mode(3'b011);
    do_start(1);
    pulse(3, 15);
    expect_out(1'b1, 1'b0, "R3 mode 011 no tick after 15 edges");
    pulse(3, 1);
    expect_out(1'b0, 1'b1, "R3 mode 011 tick on 16th edge");
    do_stop();

    // prescaler cleared on mode change
    do_start(1);
    pulse(3, 10);
    set_mode(3'b010);
    set_mode(3'b011);
    pulse(3, 15);
    expect_out(1'b1, 1'b0, "R11 partial group discarded");
    pulse(3, 1);
    expect_out(1'b0, 1'b1, "R11 full group after clear");
    do_stop();

    // timer on external pin
    set_mode(3'b100);
    do_start(2);
    pulse(0, 1);
    expect_out(1'b1, 1'b0, "R7 first half period");
    pulse(0, 1);
    expect_out(1'b0, 1'b1, "R7 first toggle low, R4 mode 100");
    pulse(0, 2);
    expect_out(1'b1, 1'b1, "R7 second toggle high");
    pulse(0, 2);
    expect_out(1'b0, 1'b1, "R7 third toggle low");
    do_stop();
    expect_out(1'b1, 1'b0, "R8 stop clears ready in timer");

    // timer on crystal
    set_mode(3'b110);
    do_start(1);
    pulse(3, 1);
    expect_out(1'b0, 1'b1, "R4 mode 110 toggle");
    pulse(3, 1);
    expect_out(1'b1, 1'b1, "R4 mode 110 toggle back");
    do_stop();

    // timer external / 16
    set_mode(3'b101);
    do_start(1);
    pulse(0, 15);
    expect_out(1'b1, 1'b0, "R3 mode 101 no tick after 15");
    pulse(0, 1);
    expect_out(1'b0, 1'b1, "R3 mode 101 toggles on 16th");
    do_stop();

    // timer crystal / 16
    set_mode(3'b111);
    do_start(2);
    pulse(3, 31);
    expect_out(1'b1, 1'b0, "R3 mode 111 before 32 edges");
    pulse(3, 1);
    expect_out(1'b0, 1'b1, "R3 mode 111 toggles at 32 edges");
    do_stop();

    // restart and stop priority
    set_mode(3'b000);
    do_start(3);
    pulse(0, 2);
    do_start(3);
    expect_out(1'b1, 1'b0, "R12 restart mid count");
    pulse(0, 2);
    expect_out(1'b1, 1'b0, "R12 count reloaded");
    pulse(0, 1);
    expect_out(1'b0, 1'b1, "R12 terminal after reload");
    step();
    preload = CNT_W'(1);
    start = 1'b1;
    stop  = 1'b1;
    step();
    start = 1'b0;
    stop  = 1'b0;
    expect_out(1'b1, 1'b0, "R12 stop wins over start");
    pulse(0, 3);
    expect_out(1'b1, 1'b0, "R12 idle after coincident strobes");

    while (q.size() > 0) @(negedge clk);
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule